// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block emits a programmable number of clock pulses toward a configuration port. Software programs it through a small 32-bit register window. Writing the count register starts a burst of that many pulses at once. The block then sets a sticky completion flag in the status register. Software polls that flag and clears it by writing a one. A typical sequence has three steps: clear the flag, write the count, and poll until the flag is set. A final write then clears the flag again. Bursts of 256 and 2047 pulses are the common lengths.

The pulse output is a clock enable that is synchronous to the system clock. It is high for exactly one cycle per pulse, so the downstream clock gate sees no glitches. The count register reads back the number of pulses still to be sent. The status register reads back the flag.

Top module: `burst_clk_gen`

## Requirements
- R1: After reset `pulse_en_o` is 0, the count register reads 0 and the status register reads 0.
- R2: A register write of value N to byte offset 0x08 loads the pulse count. For N nonzero, `pulse_en_o` is high for exactly N consecutive cycles, starting in the cycle after the write edge, and then stays low. Only the low CNT_W bits (default 12) of the written value are used.
- R3: The flag (status bit 0) becomes 1 in the cycle after the last pulse. It stays 1 until it is cleared.
- R4: A write of zero to the count register produces no pulse. The flag reads 1 in the cycle after the write.
- R5: A write to byte offset 0x0C with data bit 0 set clears the flag. A write there with bit 0 clear leaves the flag unchanged.
- R6: If the final pulse of a burst and a clearing write share a cycle, the flag is 1 afterwards, because setting takes priority.
- R7: A count write during a burst restarts it with the new value, even on the burst's last pulse. The abandoned burst never sets the flag.
- R8: Offset 0x08 reads the remaining pulse count, zero-extended. Offset 0x0C reads the flag in bit 0 and zeros above it. Any other offset reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pulse_en_o | output | 1 | One-cycle clock enable per configuration pulse |

## Verification
Two events can land in the same cycle. One is the burst's last decrement, which sets the flag. The other is a software write, either a clearing write to the status register or a new count write. The bench tracks the pulse edges of a three-pulse burst and issues the clearing write exactly on the third pulse. It expects the flag to read 1 afterwards. The same write issued one pulse earlier must read 0 and then 1. A reload issued on the final pulse must yield exactly the new count of pulses, with the flag still 0 when the new burst begins.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned OFS_COUNT = 32'h08;
  localparam int unsigned OFS_STAT  = 32'h0C;
endpackage

// File: rtl/burst_regif.sv
module burst_regif
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  remain_i,
  input  logic              done_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic             sel_cnt, sel_st, wr;
  logic [REG_W-1:0] cnt_rd;
  logic [REG_W-1:0] unused_wdata;

  assign unused_wdata = wdata_i;
  assign sel_cnt      = (addr_i == ADDR_W'(OFS_COUNT));
  assign sel_st       = (addr_i == ADDR_W'(OFS_STAT));
  assign wr           = req_i & we_i;

  assign load_o     = wr & sel_cnt;
  assign load_val_o = wdata_i[CNT_W-1:0];
  assign clr_o      = wr & sel_st & wdata_i[0];

  generate
    if (CNT_W < REG_W) begin : g_ext
      assign cnt_rd = {{(REG_W-CNT_W){1'b0}}, remain_i};
    end else begin : g_full
      assign cnt_rd = remain_i[REG_W-1:0];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (sel_cnt)     rdata_o    = cnt_rd;
    else if (sel_st) rdata_o[0] = done_i;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             pulse_o,
  output logic             last_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              remain_q <= '0;
    else if (load_i)          remain_q <= load_val_i;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign remain_o = remain_q;
  assign pulse_o  = (remain_q != '0);
  // final decrement; a reload in the same cycle abandons the burst
  assign last_o   = (remain_q == CNT_W'(1)) & ~load_i;
  assign zero_o   = load_i & (load_val_i == '0);

  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q != '0 && !load_i) |=> remain_q == $past(remain_q) - 1'b1);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q == '0 && !load_i) |=> remain_q == '0);
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> remain_q == $past(load_val_i));
endmodule

// File: rtl/burst_done_flag.sv
module burst_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o
);
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b0;
    else if (set_i)  done_q <= 1'b1;
    else if (clr_i)  done_q <= 1'b0;
  end

  assign done_o = done_q;

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> done_q);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> done_q);
  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !done_q);
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              pulse_en_o
);
  logic             load, clr, last, zero, done;
  logic [CNT_W-1:0] load_val, remain;

  burst_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regif (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .remain_i   (remain),
    .done_i     (done),
    .load_o     (load),
    .load_val_o (load_val),
    .clr_o      (clr),
    .rdata_o    (rdata_o)
  );

  burst_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .remain_o   (remain),
    .pulse_o    (pulse_en_o),
    .last_o     (last),
    .zero_o     (zero)
  );

  burst_done_flag i_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (last | zero),
    .clr_i  (clr),
    .done_o (done)
  );

  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero |=> (done && !pulse_en_o));
  p_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> (done && !pulse_en_o));
endmodule

// File: tb/test_burst_clk_gen.sv
`timescale 1ns/1ps
module test_burst_clk_gen;
  localparam int unsigned ADDR_W = 8;
  localparam logic [7:0] A_CNT = 8'h08;
  localparam logic [7:0] A_ST  = 8'h0C;
  localparam int unsigned NVEC = 6;
  localparam int unsigned VEC [NVEC] = '{1, 2, 5, 256, 'h7FF, 0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic              pulse;
  int                n_chk = 0, n_fail = 0;
  bit                finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_clk_gen #(.ADDR_W(ADDR_W), .CNT_W(12)) i_burst_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pulse_en_o(pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic count_pulses(output int n);
    n = 0;
    while (pulse) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pulse", {31'b0, pulse}, 32'd0);
    rd(A_CNT, d); check("R1 count", d, 32'd0);
    rd(A_ST, d);  check("R1 status", d, 32'd0);

    // table walk: R2 pulse count, R3/R4 flag
    for (int i = 0; i < NVEC; i++) begin
      bus_wr(A_ST, 32'h1);
      bus_wr(A_CNT, VEC[i]);
      count_pulses(n);
      check(VEC[i] == 0 ? "R4 pulses" : "R2 pulses", n, VEC[i]);
      rd(A_ST, d);
      check(VEC[i] == 0 ? "R4 flag" : "R3 flag", d, 32'h1);
    end

    // R3 sticky, R5 write of zero ignored, then clear
    repeat (5) @(negedge clk);
    rd(A_ST, d); check("R3 sticky", d, 32'h1);
    bus_wr(A_ST, 32'hFFFF_FFFE);
    rd(A_ST, d); check("R5 bit0 clear ignored", d, 32'h1);
    bus_wr(A_ST, 32'h1);
    rd(A_ST, d); check("R5 cleared", d, 32'h0);

    // R2 truncation to 12 bits: 0x1003 -> 3 pulses
    bus_wr(A_CNT, 32'h1003);
    count_pulses(n);
    check("R2 truncated", n, 32'd3);
    bus_wr(A_ST, 32'h1);

    // R8 readback of remaining count, other offsets
    bus_wr(A_CNT, 32'd10);
    rd(A_CNT, d); check("R8 count rd", d, 32'd10);
    @(negedge clk);
    rd(A_CNT, d); check("R8 count dec", d, 32'd9);
    rd(8'h04, d); check("R8 other rd", d, 32'd0);
    count_pulses(n);
    bus_wr(8'h04, 32'h1);
    rd(A_ST, d); check("R8 stray clear ignored", d, 32'h1);
    bus_wr(8'h10, 32'd7);
    check("R8 stray load ignored", {31'b0, pulse}, 32'd0);
    rd(A_CNT, d); check("R8 count idle", d, 32'd0);

    // R7 restart mid burst
    bus_wr(A_ST, 32'h1);
    bus_wr(A_CNT, 32'd20);
    @(negedge clk); @(negedge clk);
    bus_wr(A_CNT, 32'd5);
    rd(A_ST, d); check("R7 no flag mid", d, 32'h0);
    count_pulses(n);
    check("R7 restart pulses", n, 32'd5);

    // R7 restart on the final pulse
    bus_wr(A_ST, 32'h1);
    bus_wr(A_CNT, 32'd3);
    @(negedge clk); @(negedge clk);
    bus_wr(A_CNT, 32'd4);
    rd(A_ST, d); check("R7 no flag at last", d, 32'h0);
    count_pulses(n);
    check("R7 last restart pulses", n, 32'd4);
    rd(A_ST, d); check("R7 flag after new burst", d, 32'h1);

    // R6 clear one pulse early: cleared, then set
    bus_wr(A_CNT, 32'd3);
    @(negedge clk);
    bus_wr(A_ST, 32'h1);
    rd(A_ST, d); check("R5 early clear", d, 32'h0);
    check("R2 third pulse", {31'b0, pulse}, 32'd1);
    @(negedge clk);
    rd(A_ST, d); check("R3 set after early clear", d, 32'h1);

    // R6 clear on the final pulse: set wins
    bus_wr(A_CNT, 32'd3);
    @(negedge clk); @(negedge clk);
    bus_wr(A_ST, 32'h1);
    rd(A_ST, d); check("R6 set wins", d, 32'h1);
    check("R6 pulse ended", {31'b0, pulse}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule